// File: doc/BRIEF.md
# Rewind FIFO with Programmable Level Flags

A single-clock first-in first-out buffer with a fixed data width and a power-of-two depth. Two status pins change meaning with a mode latched at master reset. In standard mode they are an empty flag and a full flag, and a read request loads the data register. In fall-through mode they are an output-ready flag and an input-ready flag, and the head word is presented on the data outputs without any read request. Two level flags compare the stored word count and the free space against offsets. The offsets come from a two-bit select that is latched at master reset.

A mark input records the current read position. A retransmit input rewinds the read pointer to the last recorded position, so a block of data can be read again. Master reset clears the contents and reloads the configuration. Partial reset clears the contents and keeps the configuration. The data outputs float when output enable is low. The flags are unaffected by output enable.

Top module: `rewind_fifo`

## Requirements
- R1: A synchronous master reset (`mrst_i` high at a clock edge) empties the FIFO, clears the saved mark and the data register to zero, latches `fwft_sel_i` as the mode (0 = standard, 1 = fall-through) and latches `off_sel_i` as the offset select.
- R2: A synchronous partial reset (`prst_i` high, `mrst_i` low) empties the FIFO and clears the mark and the data register, and keeps the latched mode and offset select unchanged.
- R3: In standard mode `st_out_o` is 1 exactly when 0 words are stored and `st_in_o` is 1 exactly when DEPTH words are stored. A read of a non-empty FIFO loads the oldest unread word into the data register at that edge.
- R4: In fall-through mode `st_out_o` is 1 exactly when at least one word is stored, and that word is on the data outputs. `st_in_o` is 1 exactly when fewer than DEPTH words are stored. A word written into an empty FIFO appears on the outputs at the same edge that stores it, with no read request. A read removes the shown word and presents the next one.
- R5: `almost_empty_o` is 1 when the stored count is greater than or equal to the empty offset, and 0 otherwise.
- R6: `almost_full_o` is 1 when the number of free locations is greater than the full offset, and 0 otherwise.
- R7: Offset select codes 0, 1, 2 and 3 give offsets of 7, 15, 63 and 127 words. The same value is used for both the empty offset and the full offset.
- R8: A write while DEPTH words are stored is ignored. A read while 0 words are stored is ignored. Neither moves a pointer or changes the data register.
- R9: `mark_i` saves the current read position, and the latest mark replaces any earlier one. `rexmit_i` sets the read position to the saved mark, and a read on the same cycle is ignored. The count and all flags follow from the restored position at that edge.
- R10: When `mark_i` and `rexmit_i` are high on the same cycle, the read position moves to the previously saved mark. The new mark holds the read position from before that edge.
- R11: With `oe_i` low, `rd_data_o` is high impedance. The status and level flags are the same as with `oe_i` high.
- R12: Words leave in the order they were written, including when a read and a write fall on the same edge.
- R13: The asynchronous reset `rst_ni` low empties the FIFO and selects standard mode with offset select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrst_i | input | 1 | Master reset, synchronous, reloads configuration |
| prst_i | input | 1 | Partial reset, synchronous, keeps configuration |
| fwft_sel_i | input | 1 | Mode sampled at master reset: 1 = fall-through |
| off_sel_i | input | 2 | Offset select sampled at master reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| mark_i | input | 1 | Save the current read position |
| rexmit_i | input | 1 | Rewind the read position to the saved mark |
| oe_i | input | 1 | Output enable for rd_data_o |
| rd_data_o | output | DW | Data outputs, high impedance when oe_i is low |
| st_out_o | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| st_in_o | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| almost_empty_o | output | 1 | Count is at least the empty offset |
| almost_full_o | output | 1 | Free space exceeds the full offset |

## Verification
The bench builds the block with DEPTH = 128 and DW = 16. At this depth every offset code, including 127, gives a flag threshold that can be reached. With code 3, `almost_full_o` is high only when the FIFO is empty, and `almost_empty_o` is high only at 127 and 128 words. The shallow depth also means the fill, drain and overflow phases reach full and empty in a few hundred cycles in both modes. Random retransmits are issued only while the words since the mark still fit in 128 locations, so every rewind replays data that is still stored.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  // default level offset per select code (same for empty and full side)
  function automatic int unsigned dflt_offset(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7;
      2'd1:    return 15;
      2'd2:    return 63;
      default: return 127;
    endcase
  endfunction

endpackage

// File: rtl/rewind_fifo_mem.sv
module rewind_fifo_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/rewind_fifo_ptr.sv
module rewind_fifo_ptr #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          mark_i,
  input  logic          rexmit_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] rptr_nxt_o,
  output logic [PW-1:0] mark_o,
  output logic [PW-1:0] count_o,
  output logic [PW-1:0] count_nxt_o
);

  logic [PW-1:0] wptr_q, rptr_q, mark_q;
  logic [PW-1:0] wptr_nxt, rptr_nxt;

  always_comb begin
    wptr_nxt = wptr_q;
    rptr_nxt = rptr_q;
    if (clr_i) begin
      wptr_nxt = '0;
      rptr_nxt = '0;
    end else begin
      if (push_i)        wptr_nxt = wptr_q + PW'(1);
      if (rexmit_i)      rptr_nxt = mark_q;  // rewind wins over read
      else if (pop_i)    rptr_nxt = rptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mark_q <= '0;
    end else begin
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
      if (clr_i)       mark_q <= '0;
      else if (mark_i) mark_q <= rptr_q;  // pre-edge position, even with rexmit
    end
  end

  assign wptr_o      = wptr_q;
  assign rptr_o      = rptr_q;
  assign rptr_nxt_o  = rptr_nxt;
  assign mark_o      = mark_q;
  assign count_o     = wptr_q - rptr_q;
  assign count_nxt_o = wptr_nxt - rptr_nxt;

endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  fifo_mode_e    mode_i,
  input  logic [1:0]    sel_i,
  input  logic [PW-1:0] count_i,
  output logic          st_out_o,
  output logic          st_in_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] off;
  logic [PW-1:0] free;
  logic          is_empty, is_full;

  assign off      = PW'(dflt_offset(sel_i));
  assign free     = DEPTH_P - count_i;
  assign is_empty = (count_i == '0);
  assign is_full  = (count_i == DEPTH_P);

  // fall-through mode reports readiness, i.e. inverted sense
  assign st_out_o = (mode_i == MODE_FWFT) ? !is_empty : is_empty;
  assign st_in_o  = (mode_i == MODE_FWFT) ? !is_full  : is_full;

  assign almost_empty_o = (count_i >= off);
  assign almost_full_o  = (free > off);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          fwft_sel_i,
  input  logic [1:0]    off_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          mark_i,
  input  logic          rexmit_i,
  input  logic          oe_i,
  output wire  [DW-1:0] rd_data_o,
  output logic          st_out_o,
  output logic          st_in_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  fifo_mode_e    mode_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] wptr, rptr, rptr_nxt, mark_ptr, count, count_nxt;
  logic [AW-1:0] raddr;
  logic          clr, push, pop, fwd, is_fwft;

  // configuration: loaded only by master reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      sel_q  <= '0;
    end else if (mrst_i) begin
      mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
      sel_q  <= off_sel_i;
    end
  end

  assign is_fwft = (mode_q == MODE_FWFT);
  assign clr     = mrst_i | prst_i;
  assign push    = wr_en_i && (count != DEPTH_P) && !clr;
  assign pop     = rd_en_i && (count != '0) && !rexmit_i && !clr;

  rewind_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .push_i     (push),
    .pop_i      (pop),
    .mark_i     (mark_i),
    .rexmit_i   (rexmit_i),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .rptr_nxt_o (rptr_nxt),
    .mark_o     (mark_ptr),
    .count_o    (count),
    .count_nxt_o(count_nxt)
  );

  // fall-through prefetches the next head, standard reads the current one
  assign raddr = is_fwft ? rptr_nxt[AW-1:0] : rptr[AW-1:0];
  assign fwd   = push && (wptr == rptr_nxt);

  rewind_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (push),
    .waddr_i(wptr[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
    end else if (clr) begin
      dout_q <= '0;
    end else if (is_fwft) begin
      if (count_nxt != '0) dout_q <= fwd ? wr_data_i : mem_rdata;
    end else if (pop) begin
      dout_q <= mem_rdata;
    end
  end

  assign rd_data_o = oe_i ? dout_q : {DW{1'bz}};

  rewind_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .mode_i        (mode_q),
    .sel_i         (sel_q),
    .count_i       (count),
    .st_out_o      (st_out_o),
    .st_in_o       (st_in_o),
    .almost_empty_o(almost_empty_o),
    .almost_full_o (almost_full_o)
  );

endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int DW = 32,
  parameter int PW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mrst_i,
  input logic          prst_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          mark_i,
  input logic          rexmit_i,
  input logic          is_fwft,
  input logic [1:0]    sel_q,
  input logic          st_out_o,
  input logic          st_in_o,
  input logic [PW-1:0] count,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] mark_ptr,
  input logic [DW-1:0] dout_q
);

  a_r1_mrst_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (count == '0) && (dout_q == '0) && (mark_ptr == '0));

  a_r2_prst_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prst_i && !mrst_i) |=> $stable(is_fwft) && $stable(sel_q) && (count == '0));

  a_r3_std_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_fwft |-> !(st_out_o && st_in_o));

  a_r4_fwft_never_stuck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_fwft |-> (st_out_o || st_in_o));

  a_r8_full_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_fwft && st_in_o && wr_en_i && !rd_en_i && !rexmit_i && !mrst_i && !prst_i)
      |=> st_in_o && $stable(rptr));

  a_r8_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_fwft && st_out_o && rd_en_i && !wr_en_i && !rexmit_i && !mrst_i && !prst_i)
      |=> st_out_o && $stable(dout_q) && $stable(rptr));

  a_r9_rewind_to_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rexmit_i && !mrst_i && !prst_i) |=> (rptr == $past(mark_ptr)));

  a_r10_mark_takes_old_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !mrst_i && !prst_i) |=> (mark_ptr == $past(rptr)));

endmodule

bind rewind_fifo rewind_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mrst_i  (mrst_i),
  .prst_i  (prst_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .mark_i  (mark_i),
  .rexmit_i(rexmit_i),
  .is_fwft (is_fwft),
  .sel_q   (sel_q),
  .st_out_o(st_out_o),
  .st_in_o (st_in_o),
  .count   (count),
  .rptr    (rptr),
  .mark_ptr(mark_ptr),
  .dout_q  (dout_q)
);

// File: tb/rewind_fifo_tb.sv
`timescale 1ns/1ps
module rewind_fifo_tb;

  localparam int DW = 16;
  localparam int D  = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mrst = 0, prst = 0, fwft = 0, wr = 0, rd = 0, mark = 0, rex = 0, oe = 1;
  logic [1:0]    sel = 0;
  logic [DW-1:0] wd = '0;
  wire  [DW-1:0] rdata;
  logic          st_out, st_in, ae, af;

  always #10 clk = ~clk;

  rewind_fifo #(.DW(DW), .DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .prst_i(prst),
    .fwft_sel_i(fwft), .off_sel_i(sel), .wr_en_i(wr), .wr_data_i(wd),
    .rd_en_i(rd), .mark_i(mark), .rexmit_i(rex), .oe_i(oe),
    .rd_data_o(rdata), .st_out_o(st_out), .st_in_o(st_in),
    .almost_empty_o(ae), .almost_full_o(af)
  );

  int tests = 0, fails = 0;
  string phase = "R13";

  // reference model
  logic [DW-1:0] mm [D];
  int wp = 0, rp = 0, mk = 0;
  bit m_fwft = 0;
  int m_sel = 0;
  logic [DW-1:0] dexp = '0;

  function automatic int off_of(int s);  // R7 table
    case (s) 0: return 7; 1: return 15; 2: return 63; default: return 127; endcase
  endfunction

  task automatic model_edge();
    int cnt;
    bit wok, rok;
    if (mrst) begin m_fwft = fwft; m_sel = int'(sel); end
    if (mrst || prst) begin wp = 0; rp = 0; mk = 0; dexp = '0; return; end
    cnt = wp - rp;
    wok = wr && (cnt != D);
    rok = rd && (cnt != 0) && !rex;
    if (!m_fwft && rok) dexp = mm[rp % D];
    if (wok) begin mm[wp % D] = wd; wp++; end
    begin
      int nrp = rex ? mk : (rok ? rp + 1 : rp);
      if (mark) mk = rp;
      rp = nrp;
    end
    if (m_fwft && (wp - rp != 0)) dexp = mm[rp % D];
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  task automatic compare();
    int cnt = wp - rp;
    bit e0 = m_fwft ? (cnt != 0) : (cnt == 0);
    bit e1 = m_fwft ? (cnt != D) : (cnt == D);
    string sreq = m_fwft ? "R4" : "R3";
    chk(st_out == e0, sreq, "st_out", st_out, e0);
    chk(st_in == e1, sreq, "st_in", st_in, e1);
    chk(ae == (cnt >= off_of(m_sel)), "R5", "almost_empty", ae, cnt >= off_of(m_sel));
    chk(af == ((D - cnt) > off_of(m_sel)), "R6", "almost_full", af, (D - cnt) > off_of(m_sel));
    if (oe) chk(rdata == dexp, "R12", "rd_data", rdata, dexp);
    else chk((rdata === {DW{1'bz}}) || (rdata == '0), "R11", "rd_data floating", rdata, 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr = 0; rd = 0; mark = 0; rex = 0; mrst = 0; prst = 0; oe = 1;
  endtask

  task automatic do_mrst(bit f, logic [1:0] s);
    idle(); mrst = 1; fwft = f; sel = s; step(); mrst = 0;
  endtask

  task automatic rnd(int n, int pw, int pr, int pmk, int prx, int poe);
    for (int i = 0; i < n; i++) begin
      wr   = ($urandom % 100) < pw;
      wd   = DW'($urandom);
      rd   = ($urandom % 100) < pr;
      mark = ($urandom % 100) < pmk;
      rex  = (($urandom % 100) < prx) && (wp - mk < D);
      oe   = ($urandom % 100) >= poe;
      step();
    end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R13: asynchronous reset state
    @(negedge clk);
    compare();
    rst_n = 1;
    @(negedge clk);
    compare();

    // R1: master reset into standard mode, select 0
    phase = "R1";
    do_mrst(0, 2'd0);

    // R8: overfill then overdrain
    phase = "R8";
    for (int i = 0; i < D + 3; i++) begin wr = 1; wd = DW'(i * 37 + 5); step(); end
    idle();
    for (int i = 0; i < D + 3; i++) begin rd = 1; step(); end
    idle();

    // R12 / R9: random traffic in standard mode
    phase = "R12";
    rnd(1500, 55, 45, 5, 3, 10);
    do_mrst(0, 2'd1);
    phase = "R7";
    rnd(600, 80, 20, 2, 1, 0);
    rnd(600, 20, 80, 2, 1, 0);

    // R4: fall-through, first word with no read
    phase = "R4";
    do_mrst(1, 2'd2);
    wr = 1; wd = 16'hA5C3; step(); idle();
    step();
    rd = 1; step(); idle();
    rnd(1500, 55, 45, 5, 3, 10);
    rnd(500, 85, 15, 2, 1, 0);
    rnd(500, 15, 85, 2, 1, 0);

    // R9: rewind replays from the mark in fall-through
    phase = "R9";
    do_mrst(1, 2'd3);
    for (int i = 0; i < 6; i++) begin wr = 1; wd = DW'(16'h100 + i); step(); end
    idle(); mark = 1; step(); idle();
    for (int i = 0; i < 3; i++) begin rd = 1; step(); end
    idle(); rex = 1; rd = 1; step(); idle();
    step();

    // R10: mark and retransmit on one cycle (standard mode)
    phase = "R10";
    do_mrst(0, 2'd0);
    for (int i = 0; i < 10; i++) begin wr = 1; wd = DW'(16'h200 + i); step(); end
    idle();
    for (int i = 0; i < 3; i++) begin rd = 1; step(); end
    idle(); mark = 1; step(); idle();
    for (int i = 0; i < 2; i++) begin rd = 1; step(); end
    idle(); mark = 1; rex = 1; step(); idle();
    rd = 1; step(); idle();
    rex = 1; step(); idle();
    rd = 1; step(); step(); idle();

    // R7: offset 127, fill to the top
    phase = "R7";
    do_mrst(0, 2'd3);
    for (int i = 0; i < D; i++) begin wr = 1; wd = DW'($urandom); step(); end
    idle();
    for (int i = 0; i < 3; i++) begin rd = 1; step(); end
    idle();

    // R2: partial reset keeps fall-through mode and select 3
    phase = "R2";
    do_mrst(1, 2'd3);
    rnd(200, 70, 20, 3, 1, 0);
    prst = 1; fwft = 0; sel = 2'd0; step(); idle();
    rnd(300, 60, 40, 3, 2, 0);

    // R11: output enable toggling, flags must match regardless
    phase = "R11";
    rnd(400, 50, 50, 3, 2, 50);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule